// File: doc/BRIEF.md
# Entropy Pool Random Generator

This block produces random words from three internal 32-bit shift-register pools. There is no seed port. The pools start from fixed non-zero reset values and change only through their own feedback. A raw entropy bit arrives on an input, standing in for a sampled oscillator. A parameter either folds that bit into the primary and secondary pools or ignores it. When the bit is ignored, the word sequence is fully repeatable after the same reset and enable history.

A controller walks through idle, collect, mix and ready phases. While enabled, it spends a parameterized number of cycles collecting. Each collect cycle advances all three pools once. It then spends one cycle combining the pools into an output word and a health flag, and then holds the word as valid. A consumer pulses a request while the word is valid to start the next round. Dropping enable returns the block to idle. The pool contents are kept when this happens.

Top module: `entropy_pool_rng`

## Requirements
- R1: After reset, `word_o` is zero and `valid_o`, `low_entropy_o` and `health_fail_o` are all low.
- R2: Reset values: the primary pool loads 32'h0000_0001, the secondary pool loads all ones, and the auxiliary pool loads 32'hABCD_E971. Each pool shifts left by one and inserts its feedback at bit 0. The feedback is the XOR of the tapped bits. The tapped bit indices are {31,21,1,0} for the primary pool, {31,29,25,24} for the secondary pool and {31,30,28,0} for the auxiliary pool.
- R3: A round takes exactly `SAMPLE_TARGET` collect cycles, and each pool advances once per collect cycle. `low_entropy_o` is high in exactly those cycles.
- R4: `valid_o` rises `SAMPLE_TARGET`+2 clock edges after the edge that first samples `enable_i` high in idle, or `next_i` high while valid. `valid_o` is high only in the ready phase.
- R5: While valid, `word_o` is stable unless `next_i` is high. `next_i` high while valid clears `valid_o` at the next edge and starts a new collection.
- R6: With `USE_RAW`=1, `raw_bit_i` is XORed into the feedback bit of the primary and secondary pools on every collect cycle. With `USE_RAW`=0, `raw_bit_i` has no effect on any output.
- R7: For a 32-bit slice, the word is bswap(primary) ^ hswap(secondary) ^ aux. Here bswap reverses the byte order and hswap exchanges bits [31:16] with [15:0]. For a wider `DATA_W`, slice k applies the same formula to pools rotated left by k bits.
- R8: `health_fail_o` is loaded together with each word. It is high exactly when that word is all zeros or all ones.
- R9: `enable_i` low sends the block to idle at the next edge. `valid_o` and `low_entropy_o` clear, and the pool contents are kept for the next round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run the generator; low forces idle |
| next_i | input | 1 | Request a fresh word while valid |
| raw_bit_i | input | 1 | Raw entropy sample |
| valid_o | output | 1 | Word available (ready phase) |
| word_o | output | DATA_W | Mixed random word |
| low_entropy_o | output | 1 | Collection still in progress |
| health_fail_o | output | 1 | Last word was all zeros or all ones |

## Verification
The checker assumes that `enable_i` and `next_i` are synchronous single-bit levels. It assumes that `next_i` is only meaningful while `valid_o` is high. It assumes that `raw_bit_i` may change every cycle. The bench drives every input half a cycle away from the sampling edge. It pulses `next_i` for exactly one cycle in the ready phase, and it drives `raw_bit_i` from its own shift register. It predicts each word from a model of the pools. This model advances only in cycles where `low_entropy_o` and `enable_i` are both high.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int POOL_W = 32;
  localparam logic [POOL_W-1:0] PRI_SEED = 32'h0000_0001;
  localparam logic [POOL_W-1:0] SEC_SEED = 32'hFFFF_FFFF;
  localparam logic [POOL_W-1:0] AUX_SEED = 32'hABCD_E971;
  localparam logic [POOL_W-1:0] PRI_TAPS = 32'h8020_0003;
  localparam logic [POOL_W-1:0] SEC_TAPS = 32'hA300_0000;
  localparam logic [POOL_W-1:0] AUX_TAPS = 32'hD000_0001;

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_MIX, ST_READY} rng_state_e;

  function automatic logic [POOL_W-1:0] bswap(input logic [POOL_W-1:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [POOL_W-1:0] hswap(input logic [POOL_W-1:0] x);
    return {x[15:0], x[31:16]};
  endfunction

  function automatic logic [POOL_W-1:0] rotl(input logic [POOL_W-1:0] x, input int k);
    return (x << k) | (x >> (POOL_W - k));
  endfunction
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
  parameter int W = 32,
  parameter logic [W-1:0] TAPS = '1,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         inj_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic fb;

  assign fb = (^(q & TAPS)) ^ inj_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else if (step_i) q <= {q[W-2:0], fb};
  end

  assign q_o = q;
endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl
  import rng_pkg::*;
#(
  parameter int SAMPLE_TARGET = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       next_i,
  output logic       step_o,
  output logic       load_o,
  output rng_state_e state_o
);
  localparam int CNT_W = $clog2(SAMPLE_TARGET + 1);

  rng_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!enable_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE:    state_d = ST_COLLECT;
        ST_COLLECT: begin
          if (cnt_q == CNT_W'(SAMPLE_TARGET - 1)) begin
            state_d = ST_MIX;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_MIX:   state_d = ST_READY;
        ST_READY: if (next_i) state_d = ST_COLLECT;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign step_o  = enable_i && (state_q == ST_COLLECT);
  assign load_o  = enable_i && (state_q == ST_MIX);
  assign state_o = state_q;
endmodule

// File: rtl/rng_mixer.sv
module rng_mixer
  import rng_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [POOL_W-1:0] pri_i,
  input  logic [POOL_W-1:0] sec_i,
  input  logic [POOL_W-1:0] aux_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int SLICES = DATA_W / POOL_W;

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    assign word_o[k*POOL_W +: POOL_W] = bswap(rotl(pri_i, k))
                                      ^ hswap(rotl(sec_i, k))
                                      ^ rotl(aux_i, k);
  end
endmodule

// File: rtl/entropy_pool_rng.sv
module entropy_pool_rng
  import rng_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int SAMPLE_TARGET = 32,
  parameter bit USE_RAW       = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              next_i,
  input  logic              raw_bit_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] word_o,
  output logic              low_entropy_o,
  output logic              health_fail_o
);
  logic step, load, inj;
  rng_state_e state;
  logic [POOL_W-1:0] pri, sec, aux;
  logic [DATA_W-1:0] mixed, word_q;
  logic fail_q;

  if (USE_RAW) begin : g_raw
    assign inj = raw_bit_i;
  end else begin : g_det
    assign inj = 1'b0;
  end

  rng_ctrl #(.SAMPLE_TARGET(SAMPLE_TARGET)) u_ctrl (
    .clk_i, .rst_ni, .enable_i, .next_i,
    .step_o(step), .load_o(load), .state_o(state)
  );

  rng_lfsr #(.W(POOL_W), .TAPS(PRI_TAPS), .SEED(PRI_SEED)) u_pri (
    .clk_i, .rst_ni, .step_i(step), .inj_i(inj), .q_o(pri)
  );
  rng_lfsr #(.W(POOL_W), .TAPS(SEC_TAPS), .SEED(SEC_SEED)) u_sec (
    .clk_i, .rst_ni, .step_i(step), .inj_i(inj), .q_o(sec)
  );
  rng_lfsr #(.W(POOL_W), .TAPS(AUX_TAPS), .SEED(AUX_SEED)) u_aux (
    .clk_i, .rst_ni, .step_i(step), .inj_i(1'b0), .q_o(aux)
  );

  rng_mixer #(.DATA_W(DATA_W)) u_mix (
    .pri_i(pri), .sec_i(sec), .aux_i(aux), .word_o(mixed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      fail_q <= 1'b0;
    end else if (load) begin
      word_q <= mixed;
      fail_q <= (mixed == '0) || (mixed == '1);
    end
  end

  assign word_o        = word_q;
  assign health_fail_o = fail_q;
  assign valid_o       = (state == ST_READY);
  assign low_entropy_o = (state == ST_COLLECT);
endmodule

// File: rtl/entropy_pool_rng_chk.sv
module entropy_pool_rng_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              next_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] word_o,
  input logic              low_entropy_o,
  input logic              health_fail_o
);
  p_valid_low_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && low_entropy_o));

  p_rise_after_collect_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(low_entropy_o, 2) && !$past(low_entropy_o));

  p_word_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && enable_i && !next_i |=> valid_o && $stable(word_o));

  p_next_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && enable_i && next_i |=> !valid_o && low_entropy_o);

  p_health_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> health_fail_o == ((word_o == '0) || (word_o == '1)));

  p_disable_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !valid_o && !low_entropy_o);
endmodule

bind entropy_pool_rng entropy_pool_rng_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .next_i(next_i),
  .valid_o(valid_o), .word_o(word_o), .low_entropy_o(low_entropy_o),
  .health_fail_o(health_fail_o)
);

// File: tb/entropy_pool_rng_tb.sv
module entropy_pool_rng_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TARGET = 32;
  localparam int MAX_CYCLES = 20000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic enable_i = 1'b0, next_i = 1'b0, raw_bit_i = 1'b0;
  logic valid_o, low_entropy_o, health_fail_o;
  logic [31:0] word_o;
  logic d_valid, d_low, d_fail;
  logic [31:0] d_word;

  int total = 0, bad = 0, cycles = 0;
  logic [31:0] m_pri, m_sec, m_aux, d_pri, d_sec, d_aux;
  logic [15:0] src = 16'hACE1;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  entropy_pool_rng #(.DATA_W(32), .SAMPLE_TARGET(TARGET), .USE_RAW(1'b1)) u_dut (
    .clk_i, .rst_ni, .enable_i, .next_i, .raw_bit_i,
    .valid_o, .word_o, .low_entropy_o, .health_fail_o
  );
  entropy_pool_rng #(.DATA_W(32), .SAMPLE_TARGET(TARGET), .USE_RAW(1'b0)) u_dut_det (
    .clk_i, .rst_ni, .enable_i, .next_i, .raw_bit_i,
    .valid_o(d_valid), .word_o(d_word), .low_entropy_o(d_low), .health_fail_o(d_fail)
  );

  function automatic logic [31:0] adv(input logic [31:0] p, input logic [31:0] m, input logic inj);
    return {p[30:0], (^(p & m)) ^ inj};
  endfunction

  function automatic logic [31:0] mix(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    return {a[7:0], a[15:8], a[23:16], a[31:24]} ^ {b[15:0], b[31:16]} ^ c;
  endfunction

  // reference pools, advanced in cycles the ports show as collect
  always @(negedge clk_i) begin
    #1;
    if (rst_ni) begin
      src = {src[14:0], src[15] ^ src[13] ^ src[12] ^ src[10]};
      raw_bit_i = src[0];
      if (low_entropy_o && enable_i) begin
        m_pri = adv(m_pri, 32'h8020_0003, raw_bit_i);
        m_sec = adv(m_sec, 32'hA300_0000, raw_bit_i);
        m_aux = adv(m_aux, 32'hD000_0001, 1'b0);
      end
      if (d_low && enable_i) begin
        d_pri = adv(d_pri, 32'h8020_0003, 1'b0);
        d_sec = adv(d_sec, 32'hA300_0000, 1'b0);
        d_aux = adv(d_aux, 32'hD000_0001, 1'b0);
      end
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > MAX_CYCLES) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, MAX_CYCLES);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // counts negedges until valid, also counts those showing low_entropy
  task automatic wait_valid(output int lat, output int lows);
    lat = 0; lows = 0;
    while (lat < 200) begin
      @(negedge clk_i); #2;
      lat++;
      if (low_entropy_o) lows++;
      if (valid_o) break;
    end
  endtask

  task automatic t_reset();
    m_pri = 32'h0000_0001; m_sec = 32'hFFFF_FFFF; m_aux = 32'hABCD_E971;
    d_pri = m_pri; d_sec = m_sec; d_aux = m_aux;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 word", word_o, 0);
    check("R1 valid", valid_o, 0);
    check("R1 low_entropy", low_entropy_o, 0);
    check("R1 health", health_fail_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    #2 check("R9 idle while disabled", {valid_o, low_entropy_o}, 0);
  endtask

  task automatic t_first_word();
    int lat, lows;
    @(negedge clk_i); enable_i = 1'b1;
    wait_valid(lat, lows);
    check("R4 latency", lat, TARGET + 2);
    check("R3 collect cycles", lows, TARGET);
    check("R2 R7 first word", word_o, mix(m_pri, m_sec, m_aux));
    check("R6 deterministic word", d_word, mix(d_pri, d_sec, d_aux));
    check("R8 health", health_fail_o, (word_o == 0) || (word_o == '1));
  endtask

  task automatic t_hold_and_next();
    logic [31:0] prev;
    int lat, lows;
    prev = word_o;
    repeat (5) @(negedge clk_i);
    #2 check("R5 hold valid", valid_o, 1);
    check("R5 hold word", word_o, prev);
    @(negedge clk_i); next_i = 1'b1;
    @(negedge clk_i); next_i = 1'b0;
    #2 check("R5 next clears valid", {valid_o, low_entropy_o}, 2'b01);
    wait_valid(lat, lows);
    check("R4 latency after next", lat + 1, TARGET + 2);
    check("R7 second word", word_o, mix(m_pri, m_sec, m_aux));
    check("R6 deterministic second", d_word, mix(d_pri, d_sec, d_aux));
    check("R8 health second", health_fail_o, (word_o == 0) || (word_o == '1));
  endtask

  task automatic t_disable_mid();
    int lat, lows;
    @(negedge clk_i); next_i = 1'b1;
    @(negedge clk_i); next_i = 1'b0;
    repeat (10) @(negedge clk_i);
    enable_i = 1'b0;
    @(negedge clk_i); #2;
    check("R9 disable clears", {valid_o, low_entropy_o}, 0);
    repeat (3) @(negedge clk_i);
    enable_i = 1'b1;
    wait_valid(lat, lows);
    check("R3 R9 full round after re-enable", lows, TARGET);
    check("R9 pools kept", word_o, mix(m_pri, m_sec, m_aux));
    check("R6 deterministic kept", d_word, mix(d_pri, d_sec, d_aux));
    @(negedge clk_i); enable_i = 1'b0;
    @(negedge clk_i); #2;
    check("R9 disable in ready", valid_o, 0);
  endtask

  initial begin
    t_reset();
    t_first_word();
    t_hold_and_next();
    t_disable_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule